// File: doc/BRIEF.md
# Pipelined Floating-Point Less-Than Comparator

This block decides whether one binary floating-point operand is strictly smaller than another. The default format is 64-bit double precision: one sign bit, an 11-bit exponent field and a 52-bit fraction. Both widths are parameters, so narrower formats are built from the same source. The comparator never decodes exponent and fraction separately. For a finite or infinite value, the bits below the sign already rise together with magnitude. The block compares those magnitudes as unsigned integers and then fixes the ordering by the two sign bits.

Upstream logic offers a pair by raising a new-data strobe while the ready-for-data output is high. The pair is taken at the next rising clock edge. After a fixed latency the block pulses a ready output for exactly one cycle and presents the one-bit result together with an unordered flag, which is raised when either operand is not a number. The block takes one pair on every cycle, and results come out in the order the pairs went in. A synchronous reset empties the pipeline.

Top module: `fp_lt_pipe`

## Requirements
- R1: When both operands have sign bit 0, the result is 1 exactly when the unsigned value of a's low bits (all bits below the sign) is smaller than b's.
- R2: When both operands have sign bit 1, the unsigned comparison of the low bits is reversed: the result is 1 exactly when a's low bits are larger than b's.
- R3: When the sign bits differ and neither operand is zero or NaN, the result is 1 exactly when a carries sign bit 1.
- R4: Positive zero and negative zero (all bits below the sign equal to 0) compare equal, so the result is 0 for every pair of zeros in either order.
- R5: If either operand is NaN (exponent field all ones and a non-zero fraction), the result is 0 and the unordered flag is 1 in the cycle ready is high. For every other pair the flag is 0.
- R6: Subnormal operands (exponent field all zeros) and infinities (exponent field all ones, fraction zero) follow the numeric order: infinities lie beyond every finite magnitude, and subnormals lie below every normal magnitude.
- R7: A pair offered in clock cycle i, with the strobe high and ready-for-data high, produces its ready pulse in cycle i+LATENCY (default 2).
- R8: Each accepted pair gives exactly one single-cycle ready pulse, and the pulses come in the order the pairs were accepted. Ready stays low when no result is due, and the result and unordered outputs are 0 whenever ready is low.
- R9: Ready-for-data is 0 in the cycle after the reset input is sampled high and 1 in the cycle after it is sampled low. A strobe seen while it is 0 is ignored and gives no ready pulse.
- R10: A reset sampled high discards every pair in flight, and none of them produces a ready pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | 1+EXP_W+MAN_W | Left operand a |
| b_i | input | 1+EXP_W+MAN_W | Right operand b |
| nd_i | input | 1 | New-data strobe; a pair is taken when it and rfd_o are high at a rising edge |
| rfd_o | output | 1 | Ready for data: a pair may be offered |
| lt_o | output | 1 | Result: 1 when a < b, valid while rdy_o is high |
| rdy_o | output | 1 | One-cycle pulse marking a valid result |
| unord_o | output | 1 | Unordered flag: one operand was NaN, valid while rdy_o is high |

## Verification
Every result is due exactly LATENCY cycles after the cycle in which its pair was offered. When the bench records a pair, it stores the due cycle next to the expected values. On each falling edge it compares the outputs with the head of that queue when the head is due, and otherwise requires idle outputs. A late, early, missing or extra pulse is therefore reported as well as a wrong bit. The expected order and NaN status come from decoding each operand of a 6-bit format into a real number. Every ordered pair of that format is streamed through the block, with idle gaps scattered among them. Separate phases cover reset entry and exit, and a reset that arrives while a pair is still in flight.

// File: rtl/fplt_pkg.sv
package fplt_pkg;

    // One slot of the result pipeline.
    typedef struct packed {
        logic vld;
        logic lt;
        logic unord;
    } fplt_res_t;

endpackage

// File: rtl/fplt_classify.sv
module fplt_classify #(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic [EXP_W+MAN_W:0]   op_i,
    output logic                   sign_o,
    output logic [EXP_W+MAN_W-1:0] mag_o,
    output logic                   nan_o,
    output logic                   zero_o
);
    localparam int MAG_W = EXP_W + MAN_W;

    logic exp_full;
    logic frac_nz;

    always_comb begin
        sign_o   = op_i[MAG_W];
        mag_o    = op_i[MAG_W-1:0];
        exp_full = &op_i[MAG_W-1:MAN_W];
        frac_nz  = |op_i[MAN_W-1:0];
        nan_o    = exp_full & frac_nz;
        zero_o   = ~|op_i[MAG_W-1:0];
    end

endmodule

// File: rtl/fplt_order.sv
module fplt_order #(
    parameter int MAG_W = 63
) (
    input  logic             sa_i,
    input  logic [MAG_W-1:0] ma_i,
    input  logic             na_i,
    input  logic             za_i,
    input  logic             sb_i,
    input  logic [MAG_W-1:0] mb_i,
    input  logic             nb_i,
    input  logic             zb_i,
    output logic             lt_o,
    output logic             unord_o
);
    logic a_mag_lo;
    logic b_mag_lo;

    always_comb begin
        a_mag_lo = ma_i < mb_i;
        b_mag_lo = mb_i < ma_i;
        unord_o  = na_i | nb_i;
        if (unord_o || (za_i && zb_i)) begin
            lt_o = 1'b0;
        end else if (sa_i != sb_i) begin
            lt_o = sa_i;
        end else if (!sa_i) begin
            lt_o = a_mag_lo;
        end else begin
            lt_o = b_mag_lo;
        end
    end

endmodule

// File: rtl/fplt_pipe.sv
module fplt_pipe
    import fplt_pkg::*;
#(
    parameter int LATENCY = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  fplt_res_t res_i,
    output fplt_res_t res_o
);
    fplt_res_t [LATENCY-1:0] st_d;
    fplt_res_t [LATENCY-1:0] st_q;

    always_comb begin
        st_d[0] = res_i;
        for (int i = 1; i < LATENCY; i++) begin
            st_d[i] = st_q[i-1];
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign res_o = st_q[LATENCY-1];

    assert_stage_entry_R7: assert property (@(posedge clk) disable iff (rst)
        res_i.vld |=> st_q[0].vld);

    for (genvar g = 0; g < LATENCY - 1; g++) begin : g_shift_chk
        assert_stage_shift_R7: assert property (@(posedge clk) disable iff (rst)
            st_q[g].vld |=> st_q[g+1].vld);
    end

endmodule

// File: rtl/fp_lt_pipe.sv
module fp_lt_pipe
    import fplt_pkg::*;
#(
    parameter int EXP_W   = 11,
    parameter int MAN_W   = 52,
    parameter int LATENCY = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [EXP_W+MAN_W:0] a_i,
    input  logic [EXP_W+MAN_W:0] b_i,
    input  logic                 nd_i,
    output logic                 rfd_o,
    output logic [0:0]           lt_o,
    output logic                 rdy_o,
    output logic                 unord_o
);
    localparam int MAG_W = EXP_W + MAN_W;

    typedef struct packed {
        logic rfd;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    logic             sa, sb, na, nb, za, zb;
    logic [MAG_W-1:0] ma, mb;
    logic             lt_c, unord_c;
    logic             accept;
    fplt_res_t        stage_in;
    fplt_res_t        stage_out;

    fplt_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
        .op_i(a_i), .sign_o(sa), .mag_o(ma), .nan_o(na), .zero_o(za)
    );

    fplt_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
        .op_i(b_i), .sign_o(sb), .mag_o(mb), .nan_o(nb), .zero_o(zb)
    );

    fplt_order #(.MAG_W(MAG_W)) u_order (
        .sa_i(sa), .ma_i(ma), .na_i(na), .za_i(za),
        .sb_i(sb), .mb_i(mb), .nb_i(nb), .zb_i(zb),
        .lt_o(lt_c), .unord_o(unord_c)
    );

    always_comb begin
        ctl_d.rfd          = !rst;
        accept             = nd_i & ctl_q.rfd;
        stage_in.vld       = accept;
        stage_in.lt        = accept & lt_c;
        stage_in.unord     = accept & unord_c;
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    fplt_pipe #(.LATENCY(LATENCY)) u_pipe (
        .clk(clk), .rst(rst), .res_i(stage_in), .res_o(stage_out)
    );

    assign rfd_o   = ctl_q.rfd;
    assign rdy_o   = stage_out.vld;
    assign lt_o[0] = stage_out.lt;
    assign unord_o = stage_out.unord;

    assert_rfd_drop_R9: assert property (@(posedge clk)
        rst |=> !rfd_o);

    assert_rfd_rise_R9: assert property (@(posedge clk) disable iff (rst)
        !rst |=> rfd_o);

    assert_flush_R10: assert property (@(posedge clk)
        rst |=> !rdy_o);

    assert_unord_blocks_lt_R5: assert property (@(posedge clk) disable iff (rst)
        unord_o |-> !lt_o[0]);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !rdy_o |-> (!lt_o[0] && !unord_o));

endmodule

// File: tb/sim_fp_lt_pipe.sv
module sim_fp_lt_pipe;
    localparam int CLK_PERIOD = 10;
    localparam int E    = 3;
    localparam int M    = 2;
    localparam int W    = 1 + E + M;
    localparam int L    = 2;
    localparam int BIAS = (1 << (E - 1)) - 1;
    localparam int EMAX = (1 << E) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         nd  = 1'b0;
    logic [W-1:0] a   = '0;
    logic [W-1:0] b   = '0;
    logic         rfd, rdy, un;
    logic [0:0]   lt;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fp_lt_pipe #(.EXP_W(E), .MAN_W(M), .LATENCY(L)) u0 (
        .clk(clk), .rst(rst), .a_i(a), .b_i(b), .nd_i(nd),
        .rfd_o(rfd), .lt_o(lt), .rdy_o(rdy), .unord_o(un)
    );

    typedef struct {
        int           due;
        bit           lt;
        bit           un;
        string        tag;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } exp_t;

    exp_t  q[$];
    int    it       = 0;
    int    n_chk    = 0;
    int    n_fail   = 0;
    string idle_tag = "R9";

    function automatic real pow2(int n);
        real r = 1.0;
        if (n >= 0) for (int k = 0; k < n; k++) r = r * 2.0;
        else        for (int k = 0; k < -n; k++) r = r / 2.0;
        return r;
    endfunction

    function automatic real fval(logic [W-1:0] x);
        int  e = int'(x[W-2:M]);
        int  m = int'(x[M-1:0]);
        real v;
        if (e == 0)         v = real'(m) * pow2(1 - BIAS - M);
        else if (e == EMAX) v = 1.0e30;
        else                v = (pow2(M) + real'(m)) * pow2(e - BIAS - M);
        return x[W-1] ? -v : v;
    endfunction

    function automatic bit is_nan(logic [W-1:0] x);
        return (int'(x[W-2:M]) == EMAX) && (x[M-1:0] != 0);
    endfunction

    function automatic string req_tag(logic [W-1:0] x, logic [W-1:0] y);
        int ex = int'(x[W-2:M]);
        int ey = int'(y[W-2:M]);
        if (is_nan(x) || is_nan(y))                        return "R5";
        if (x[W-2:0] == 0 && y[W-2:0] == 0)                return "R4";
        if (ex == 0 || ey == 0 || ex == EMAX || ey == EMAX) return "R6";
        if (x[W-1] != y[W-1])                              return "R3";
        if (x[W-1])                                        return "R2";
        return "R1";
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic check_out();
        if (q.size() > 0 && q[0].due == it) begin
            exp_t e = q.pop_front();
            check(rdy === 1'b1, {e.tag, "/R7"}, "ready pulse", int'(rdy), 1);
            check(lt[0] === e.lt, e.tag, $sformatf("lt a=%h b=%h", e.a, e.b),
                  int'(lt[0]), int'(e.lt));
            check(un === e.un, "R5", $sformatf("unord a=%h b=%h", e.a, e.b),
                  int'(un), int'(e.un));
        end else begin
            check(rdy === 1'b0 && lt[0] === 1'b0 && un === 1'b0, idle_tag,
                  "idle outputs {rdy,lt,unord}", int'({rdy, lt[0], un}), 0);
        end
    endtask

    task automatic cycle(bit n, logic [W-1:0] av, logic [W-1:0] bv, bit r);
        @(negedge clk);
        it++;
        check_out();
        if (r) q.delete();
        rst = r;
        nd  = n;
        a   = av;
        b   = bv;
        if (n && !r && rfd === 1'b1) begin
            exp_t e;
            e.due = it + L;
            e.un  = is_nan(av) || is_nan(bv);
            e.lt  = !e.un && (fval(av) < fval(bv));
            e.tag = req_tag(av, bv);
            e.a   = av;
            e.b   = bv;
            q.push_back(e);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R9: strobes during reset are ignored; rfd held low
        for (int k = 0; k < 3; k++) begin
            cycle(1'b1, W'(1), W'(2), 1'b1);
            check(rfd === 1'b0, "R9", "rfd during reset", int'(rfd), 0);
        end
        cycle(1'b1, W'(1), W'(2), 1'b0);
        check(rfd === 1'b0, "R9", "rfd in release cycle", int'(rfd), 0);
        cycle(1'b0, '0, '0, 1'b0);
        check(rfd === 1'b1, "R9", "rfd after release", int'(rfd), 1);
        repeat (L + 1) cycle(1'b0, '0, '0, 1'b0);

        // R1..R8: every ordered pair of the small format
        idle_tag = "R8";
        for (int ia = 0; ia < (1 << W); ia++) begin
            for (int ib = 0; ib < (1 << W); ib++) begin
                cycle(1'b1, W'(ia), W'(ib), 1'b0);
                if ((ia * 7 + ib) % 29 == 0) cycle(1'b0, '0, '0, 1'b0);
            end
        end
        repeat (L + 2) cycle(1'b0, '0, '0, 1'b0);
        check(q.size() == 0, "R8", "results outstanding", q.size(), 0);

        // R10: reset while a pair is in flight
        idle_tag = "R10";
        cycle(1'b1, {1'b1, (W-1)'(5)}, W'(5), 1'b0);
        cycle(1'b0, '0, '0, 1'b1);
        repeat (L + 1) cycle(1'b1, W'(3), W'(9), 1'b1);
        check(rfd === 1'b0, "R10", "rfd while flushing", int'(rfd), 0);
        cycle(1'b0, '0, '0, 1'b0);
        repeat (L + 2) cycle(1'b0, '0, '0, 1'b0);
        check(rfd === 1'b1, "R9", "rfd after second release", int'(rfd), 1);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule